// File: doc/BRIEF.md
# Radio Control State Sequencer

This block is the main control state machine of a packet radio. Software or a bus decoder sends it single-cycle command strobes: reset, return to idle, start transmit, start receive and flush the transmit FIFO. From idle, a transmit or receive strobe takes the machine to the active state. When automatic calibration is enabled, it first passes through a calibration step and a bandwidth-boost step. It then waits for synthesizer lock before it goes active. The analog steps are modelled only as parameterised cycle counts, plus a lock handshake input that has a timeout as a fallback.

While the machine is active, it watches FIFO flags supplied from outside. A transmit underflow seen in transmit, or a receive overflow seen in receive, parks the machine in an error state until software clears it. The current state is always visible as a byte-wide code for a status readout. A 3-bit summary of the state is provided for packing into a status byte. A one-cycle acknowledge marks each flush strobe that the block accepts.

Top module: `radio_seq`

## Requirements
- R1: Holding `rst_n` low, or asserting `cmd_reset`, puts the machine in idle on the next clock edge: `state_code` reads 0x01, `state_sum` reads 0 and `flush_ack` reads 0.
- R2: `state_code` uses these values: idle 0x01, calibrate 0x08, bandwidth boost 0x09, synthesizer lock 0x0A, receive 0x0D, receive overflow 0x11, transmit 0x13, transmit underflow 0x16.
- R3: With `auto_cal`=1, a transmit or receive strobe in idle moves the machine to calibrate (0x08) on the next edge. Calibrate lasts CAL_CYCLES cycles and is followed by bandwidth boost (0x09). Bandwidth boost lasts BOOST_CYCLES cycles and is followed by synthesizer lock (0x0A).
- R4: With `auto_cal`=0, a transmit or receive strobe in idle moves the machine straight to synthesizer lock.
- R5: Synthesizer lock moves to transmit if the strobe that started the sequence was transmit, and to receive otherwise. It moves on the edge where `pll_lock` is sampled high, or after LOCK_TIMEOUT cycles in the lock state, whichever comes first.
- R6: In transmit, `txfifo_underflow` moves the machine to transmit underflow (0x16). In receive, `rxfifo_overflow` moves it to receive overflow (0x11).
- R7: Both error states ignore transmit and receive strobes and the FIFO flags. Receive overflow is left only by the idle or reset strobe. Transmit underflow is left by the idle, reset or flush strobe.
- R8: A flush strobe is accepted only in idle or transmit underflow. An accepted flush pulses `flush_ack` for one cycle after the strobe, and a flush accepted in transmit underflow also returns the machine to idle. In any other state the flush strobe changes neither `flush_ack` nor the state.
- R9: The idle strobe returns the machine to idle from every other state on the next edge, including the calibration and lock states.
- R10: Strobe priority is reset, then idle, then flush, then transmit, then receive. A flush that is beaten by a reset or idle strobe is not acknowledged. Transmit and receive strobes outside idle are ignored.
- R11: `state_sum` encodes the state as idle 0, receive 1, transmit 2, synthesizer lock 3, calibrate 4, bandwidth boost 5, receive overflow 6, transmit underflow 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_cal | input | 1 | Calibrate when leaving idle |
| cmd_reset | input | 1 | Reset strobe |
| cmd_idle | input | 1 | Idle strobe |
| cmd_tx | input | 1 | Transmit strobe |
| cmd_rx | input | 1 | Receive strobe |
| cmd_flush_tx | input | 1 | Transmit FIFO flush strobe |
| pll_lock | input | 1 | Synthesizer lock indication |
| txfifo_underflow | input | 1 | Transmit FIFO underflow flag |
| rxfifo_overflow | input | 1 | Receive FIFO overflow flag |
| state_code | output | 8 | Encoded current state |
| state_sum | output | 3 | 3-bit state summary |
| flush_ack | output | 1 | Accepted flush, one cycle |

## Verification
The state register drives `state_code` directly, so a wrong transition shows on that port one cycle after the edge that caused it. A miscounted calibration or lock timer first shows as a boundary state that appears one cycle early or late. A wrongly held target bit shows only at the end of lock, when the machine reaches receive instead of transmit or the reverse. A broken flush gate shows either as a missing `flush_ack` pulse or as a spurious one in a state where flushes must be ignored.

// File: rtl/radio_seq.sv
module radio_seq #(
  parameter int CAL_CYCLES   = 4,
  parameter int BOOST_CYCLES = 2,
  parameter int LOCK_TIMEOUT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_cal,
  input  logic       cmd_reset,
  input  logic       cmd_idle,
  input  logic       cmd_tx,
  input  logic       cmd_rx,
  input  logic       cmd_flush_tx,
  input  logic       pll_lock,
  input  logic       txfifo_underflow,
  input  logic       rxfifo_overflow,
  output logic [7:0] state_code,
  output logic [2:0] state_sum,
  output logic       flush_ack
);
  localparam int MAXC  = (CAL_CYCLES > BOOST_CYCLES) ?
                         ((CAL_CYCLES > LOCK_TIMEOUT) ? CAL_CYCLES : LOCK_TIMEOUT) :
                         ((BOOST_CYCLES > LOCK_TIMEOUT) ? BOOST_CYCLES : LOCK_TIMEOUT);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [7:0] {
    S_IDLE  = 8'h01, S_CAL  = 8'h08, S_BOOST = 8'h09, S_LOCK = 8'h0A,
    S_RX    = 8'h0D, S_RXOF = 8'h11, S_TX    = 8'h13, S_TXUF = 8'h16
  } st_t;

  st_t             st, nxt;
  logic [CNT_W-1:0] cnt;
  logic             tgt_tx;
  logic             flush_ok;
  logic             timing;

  assign flush_ok = cmd_flush_tx && !cmd_reset && !cmd_idle &&
                    (st == S_IDLE || st == S_TXUF);
  assign timing   = (st == S_CAL) || (st == S_BOOST) || (st == S_LOCK);

  always_comb begin
    nxt = st;
    if (cmd_reset || cmd_idle) nxt = S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (!cmd_flush_tx && (cmd_tx || cmd_rx)) nxt = auto_cal ? S_CAL : S_LOCK;
        S_CAL:   if (cnt == CNT_W'(CAL_CYCLES - 1)) nxt = S_BOOST;
        S_BOOST: if (cnt == CNT_W'(BOOST_CYCLES - 1)) nxt = S_LOCK;
        S_LOCK:  if (pll_lock || cnt == CNT_W'(LOCK_TIMEOUT - 1)) nxt = tgt_tx ? S_TX : S_RX;
        S_TX:    if (txfifo_underflow) nxt = S_TXUF;
        S_RX:    if (rxfifo_overflow) nxt = S_RXOF;
        S_TXUF:  if (cmd_flush_tx) nxt = S_IDLE;
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      tgt_tx    <= 1'b0;
      flush_ack <= 1'b0;
    end else begin
      st        <= nxt;
      flush_ack <= flush_ok;
      if (nxt != st) cnt <= '0;
      else if (timing) cnt <= cnt + 1'b1;
      if (st == S_IDLE && nxt != S_IDLE) tgt_tx <= cmd_tx;
    end
  end

  assign state_code = st;

  always_comb begin
    case (st)
      S_IDLE:  state_sum = 3'd0;
      S_RX:    state_sum = 3'd1;
      S_TX:    state_sum = 3'd2;
      S_LOCK:  state_sum = 3'd3;
      S_CAL:   state_sum = 3'd4;
      S_BOOST: state_sum = 3'd5;
      S_RXOF:  state_sum = 3'd6;
      default: state_sum = 3'd7;
    endcase
  end

  a_r1_reset_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> state_code == 8'h01);
  a_r3_boost_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BOOST) |-> ($past(st) == S_CAL || $past(st) == S_BOOST));
  a_r5_lock_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK) |-> (cnt < CNT_W'(LOCK_TIMEOUT)));
  a_r6_tx_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && txfifo_underflow && !cmd_reset && !cmd_idle) |=> state_code == 8'h16);
  a_r7_rxof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RXOF && !cmd_reset && !cmd_idle) |=> state_code == 8'h11);
  a_r8_flush_gated: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ack |-> ($past(st) == S_IDLE || $past(st) == S_TXUF));
  a_r9_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_idle |=> state_code == 8'h01);
endmodule

// File: tb/radio_seq_tb_top.sv
module radio_seq_tb_top;
  localparam int CAL = 4, BOOST = 2, LTO = 8;

  logic clk = 0, rst_n = 0;
  logic auto_cal = 0, cmd_reset = 0, cmd_idle = 0, cmd_tx = 0, cmd_rx = 0, cmd_flush_tx = 0;
  logic pll_lock = 0, txfifo_underflow = 0, rxfifo_overflow = 0;
  logic [7:0] state_code;
  logic [2:0] state_sum;
  logic flush_ack;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  radio_seq #(.CAL_CYCLES(CAL), .BOOST_CYCLES(BOOST), .LOCK_TIMEOUT(LTO)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_cal(auto_cal), .cmd_reset(cmd_reset),
    .cmd_idle(cmd_idle), .cmd_tx(cmd_tx), .cmd_rx(cmd_rx), .cmd_flush_tx(cmd_flush_tx),
    .pll_lock(pll_lock), .txfifo_underflow(txfifo_underflow),
    .rxfifo_overflow(rxfifo_overflow), .state_code(state_code),
    .state_sum(state_sum), .flush_ack(flush_ack));

  // reference model built from the requirements
  int m_st = 8'h01, m_cnt = 0, m_ack = 0;
  bit m_tgt = 0;

  function automatic int sum_of(int s);
    case (s)
      8'h01: return 0; 8'h0D: return 1; 8'h13: return 2; 8'h0A: return 3;
      8'h08: return 4; 8'h09: return 5; 8'h11: return 6; default: return 7;
    endcase
  endfunction

  function automatic int next_of(int s, int c, bit t);
    if (cmd_reset || cmd_idle) return 8'h01;               // R1 R9 R10
    case (s)
      8'h01: if (!cmd_flush_tx && (cmd_tx || cmd_rx)) return auto_cal ? 8'h08 : 8'h0A;
      8'h08: if (c == CAL - 1) return 8'h09;                 // R3
      8'h09: if (c == BOOST - 1) return 8'h0A;
      8'h0A: if (pll_lock || c == LTO - 1) return t ? 8'h13 : 8'h0D;  // R5
      8'h13: if (txfifo_underflow) return 8'h16;             // R6
      8'h0D: if (rxfifo_overflow) return 8'h11;
      8'h16: if (cmd_flush_tx) return 8'h01;                 // R7 R8
      default: ;
    endcase
    return s;
  endfunction

  always @(posedge clk) begin
    int n;
    if (!rst_n) begin
      m_st <= 8'h01; m_cnt <= 0; m_ack <= 0; m_tgt <= 0;
    end else begin
      n = next_of(m_st, m_cnt, m_tgt);
      m_ack <= (cmd_flush_tx && !cmd_reset && !cmd_idle && (m_st == 8'h01 || m_st == 8'h16)) ? 1 : 0;
      if (m_st == 8'h01 && n != 8'h01) m_tgt <= cmd_tx;
      if (n != m_st) m_cnt <= 0; else m_cnt <= m_cnt + 1;
      m_st <= n;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R2 state_code vs model", state_code, m_st);
    check("R11 state_sum vs model", state_sum, sum_of(m_st));
    check("R8 flush_ack vs model", flush_ack, m_ack);
  end

  task automatic step(); @(negedge clk); endtask
  task automatic clear();
    cmd_reset = 0; cmd_idle = 0; cmd_tx = 0; cmd_rx = 0; cmd_flush_tx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) step();
    rst_n = 1;
    step();
    check("R1 reset code", state_code, 8'h01);
    check("R1 reset sum", state_sum, 0);
    check("R1 reset ack", flush_ack, 0);

    // R3 automatic calibration path, R5 lock via handshake
    auto_cal = 1; cmd_tx = 1; step(); clear();
    for (int i = 0; i < CAL; i++) begin check("R3 calibrate", state_code, 8'h08); step(); end
    for (int i = 0; i < BOOST; i++) begin check("R3 boost", state_code, 8'h09); step(); end
    check("R3 lock entered", state_code, 8'h0A);
    cmd_flush_tx = 1; step(); clear();
    check("R8 flush ignored in lock", flush_ack, 0);
    pll_lock = 1; step(); pll_lock = 0;
    check("R5 lock to tx", state_code, 8'h13);
    cmd_flush_tx = 1; step(); clear();
    check("R8 flush ignored in tx", flush_ack, 0);
    check("R8 tx kept", state_code, 8'h13);
    txfifo_underflow = 1; step(); txfifo_underflow = 0;
    check("R6 underflow", state_code, 8'h16);
    check("R11 underflow sum", state_sum, 7);
    cmd_tx = 1; step(); clear();
    check("R7 underflow holds", state_code, 8'h16);
    cmd_flush_tx = 1; step(); clear();
    check("R8 flush ack", flush_ack, 1);
    check("R7 flush leaves underflow", state_code, 8'h01);
    step();
    check("R8 ack single cycle", flush_ack, 0);

    // R4 direct lock, R5 timeout to rx
    auto_cal = 0; cmd_rx = 1; step(); clear();
    for (int i = 0; i < LTO; i++) begin check("R4 R5 lock wait", state_code, 8'h0A); step(); end
    check("R5 timeout to rx", state_code, 8'h0D);
    rxfifo_overflow = 1; step(); rxfifo_overflow = 0;
    check("R6 overflow", state_code, 8'h11);
    cmd_flush_tx = 1; step(); clear();
    check("R8 flush ignored in overflow", flush_ack, 0);
    check("R7 overflow holds", state_code, 8'h11);
    cmd_idle = 1; step(); clear();
    check("R9 idle from overflow", state_code, 8'h01);

    // R10 priorities
    cmd_tx = 1; cmd_flush_tx = 1; step(); clear();
    check("R10 flush beats tx", state_code, 8'h01);
    check("R10 flush acked", flush_ack, 1);
    auto_cal = 1; cmd_rx = 1; step(); clear();
    check("R3 rx calibrates", state_code, 8'h08);
    cmd_idle = 1; cmd_tx = 1; step(); clear();
    check("R9 idle from calibrate", state_code, 8'h01);
    cmd_idle = 1; cmd_flush_tx = 1; step(); clear();
    check("R10 idle beats flush", flush_ack, 0);
    cmd_reset = 1; cmd_rx = 1; step(); clear();
    check("R1 reset strobe", state_code, 8'h01);

    // random phase, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      cmd_reset    = (r == 0);
      cmd_idle     = (r >= 1 && r <= 3);
      cmd_tx       = (r >= 4 && r <= 12);
      cmd_rx       = (r >= 10 && r <= 18);
      cmd_flush_tx = (r >= 17 && r <= 24);
      pll_lock         = ($urandom_range(0, 7) == 0);
      txfifo_underflow = ($urandom_range(0, 15) == 0);
      rxfifo_overflow  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 63) == 0) auto_cal = ~auto_cal;
      if ($urandom_range(0, 999) == 0) rst_n = 0; else rst_n = 1;
      step();
    end
    clear(); rst_n = 1; step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule